// File: doc/BRIEF.md
# Clock-Calendar Update Engine

This block holds the time of day and the calendar (seconds, minutes, hours, weekday, day of month, month and a two-digit year) in a bank of byte registers that software reads and writes through a simple single-cycle register port. A one-clock pulse on `tick_1s` starts an update. The status output `uip` stays high for `UIP_LEAD` clock cycles. At the end of that window the bank steps forward by one second and `upd_done` pulses for one cycle, so interrupt logic can use it.

Software chooses how the bytes are presented. Every field is shown either as plain binary or as two packed decimal digits. Hours use either a 0–23 count or a 1–12 count with a PM marker in bit 7. An optional daylight-saving rule jumps forward one hour on the first Sunday of April and back one hour on the last Sunday of October. The back step happens only the first time 01:59:59 is reached that morning.

A freeze control lets software set the time without seeing a half-updated bank. While the freeze bit is high, the visible bytes stop changing and accept writes, and an internal binary copy keeps counting. When the freeze bit is cleared, the visible bytes are decoded into the internal copy, and counting continues from them at the next tick.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset the register bank reads 00:00:00 in 24-hour packed-decimal mode: weekday 1, day 1, month 1, year 0. The control byte reads 0x04.
- R2: Each completed update adds one second. Carries ripple through minutes, hours (23→0), day of month (month length), month (12→1) and year (99→0). The weekday steps 7→1 when the day rolls over.
- R3: The binary-mode bit selects the encoding. Bit 1 of the control byte (address 7) set to 1 means plain binary. Set to 0, each byte holds two decimal digits, with tens in bits 7:4 and units in bits 3:0. The mode applies to every field.
- R4: The hour-format bit selects the hour format. Bit 2 of the control byte set to 1 gives 0–23. Set to 0, hours run 1–12 with bit 7 meaning PM: 11 AM rolls to 12 PM, 12 PM rolls to 1 PM, and 11 PM rolls to 12 AM.
- R5: February has 29 days when the year is a multiple of four, including year 00, and 28 days otherwise.
- R6: With the daylight-saving bit (bit 3 of the control byte) set, a Sunday (weekday 1) in April with day 1–7 steps from 01:59:59 straight to 03:00:00. With the bit clear, or on other days, the step is to 02:00:00.
- R7: With the daylight-saving bit set, a Sunday in October with day 25–31 steps from 01:59:59 back to 01:00:00 the first time. The next time 01:59:59 is reached it steps to 02:00:00.
- R8: While the freeze bit (bit 0 of the control byte) is 1, ticks leave the visible bytes unchanged, `upd_done` stays low and `uip` reads 0. Setting the bit while `uip` is high drops `uip` in the next cycle.
- R9: Clearing the freeze bit loads the visible bytes into the internal count and cancels any pending update. The next tick advances from the loaded values.
- R10: Writes to the time bytes (addresses 0–6) are ignored while the freeze bit is 0.
- R11: Bit 7 of the seconds byte (address 0) always reads 0, whatever is written.
- R12: `uip` rises in the cycle after the tick is sampled and stays high for `UIP_LEAD` cycles. The bank changes, and `upd_done` pulses for exactly one cycle, at the edge where `uip` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1s | input | 1 | One-cycle pulse per second that starts an update |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address: 0 sec, 1 min, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 7 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational); unused addresses read 0 |
| uip | output | 1 | Update-in-progress status |
| upd_done | output | 1 | One-cycle pulse after each transfer into the visible bytes |

## Verification
The assertions check on every cycle that:
- `upd_done` is a single-cycle pulse that only follows a `uip` window;
- `uip` only rises after a tick;
- the seconds top bit stays clear;
- the visible bytes hold still and no completion pulse appears while frozen.

Calendar arithmetic depends on particular dates and values, so only the bench scenarios can show it: month lengths and leap years, 12-hour PM rollovers in both encodings, the two daylight-saving jumps including the one-time fall-back, and the load on unfreeze. A behavioural model in the bench tracks `uip` and `upd_done` on every clock and the whole bank after every update.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned N_FIELDS = 7;
  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_DOW  = 3;
  localparam int unsigned F_DATE = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YR   = 6;
  localparam int unsigned A_CTL  = 7;
  localparam int unsigned C_SET  = 0;
  localparam int unsigned C_BIN  = 1;
  localparam int unsigned C_H24  = 2;
  localparam int unsigned C_DST  = 3;

  typedef logic [N_FIELDS-1:0][7:0] tm_t;

  // value -> byte in the selected encoding
  function automatic logic [7:0] to_code(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] ones;
    tens = v / 8'd10;
    ones = v - tens * 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  // byte in the selected encoding -> value
  function automatic logic [7:0] from_code(input logic [7:0] c, input logic bin);
    return bin ? c : ({4'd0, c[7:4]} * 8'd10 + {4'd0, c[3:0]});
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                     return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  tm_t  cur,
  input  logic dst_en,
  input  logic fall_seen,
  output tm_t  nxt,
  output logic fall_seen_nxt
);
  logic end_hour, day_end, spring_jump, fall_jump;

  always_comb begin
    end_hour    = (cur[F_MIN] == 8'd59) && (cur[F_SEC] == 8'd59);
    day_end     = end_hour && (cur[F_HR] == 8'd23);
    spring_jump = dst_en && (cur[F_MON] == 8'd4) && (cur[F_DOW] == 8'd1) &&
                  (cur[F_DATE] <= 8'd7) && (cur[F_HR] == 8'd1) && end_hour;
    fall_jump   = dst_en && (cur[F_MON] == 8'd10) && (cur[F_DOW] == 8'd1) &&
                  (cur[F_DATE] >= 8'd25) && (cur[F_HR] == 8'd1) && end_hour && !fall_seen;
    nxt           = cur;
    fall_seen_nxt = fall_seen;
    if (spring_jump) begin
      nxt[F_HR]  = 8'd3;
      nxt[F_MIN] = 8'd0;
      nxt[F_SEC] = 8'd0;
    end else if (fall_jump) begin
      nxt[F_MIN]    = 8'd0;
      nxt[F_SEC]    = 8'd0;
      fall_seen_nxt = 1'b1;
    end else begin
      if (end_hour && (cur[F_HR] == 8'd1)) fall_seen_nxt = 1'b0;
      nxt[F_SEC] = (cur[F_SEC] == 8'd59) ? 8'd0 : cur[F_SEC] + 8'd1;
      if (cur[F_SEC] == 8'd59)
        nxt[F_MIN] = (cur[F_MIN] == 8'd59) ? 8'd0 : cur[F_MIN] + 8'd1;
      if (end_hour)
        nxt[F_HR] = (cur[F_HR] == 8'd23) ? 8'd0 : cur[F_HR] + 8'd1;
      if (day_end) begin
        nxt[F_DOW] = (cur[F_DOW] == 8'd7) ? 8'd1 : cur[F_DOW] + 8'd1;
        if (cur[F_DATE] >= month_len(cur[F_MON], cur[F_YR])) begin
          nxt[F_DATE] = 8'd1;
          nxt[F_MON]  = (cur[F_MON] == 8'd12) ? 8'd1 : cur[F_MON] + 8'd1;
          if (cur[F_MON] == 8'd12)
            nxt[F_YR] = (cur[F_YR] == 8'd99) ? 8'd0 : cur[F_YR] + 8'd1;
        end else begin
          nxt[F_DATE] = cur[F_DATE] + 8'd1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_cal_enc.sv
module rtc_cal_enc
  import rtc_cal_pkg::*;
(
  input  tm_t  tm,
  input  logic bin,
  input  logic h24,
  output tm_t  code
);
  logic [7:0] fld [N_FIELDS];

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    if (i == F_HR) begin : g_hr
      logic [7:0] h12;
      logic [7:0] hc;
      logic       pm;
      always_comb begin
        pm = tm[i] >= 8'd12;
        if (tm[i] == 8'd0)       h12 = 8'd12;
        else if (tm[i] > 8'd12)  h12 = tm[i] - 8'd12;
        else                     h12 = tm[i];
        hc = to_code(h12, bin);
      end
      assign fld[i] = h24 ? to_code(tm[i], bin) : {pm, hc[6:0]};
    end else begin : g_plain
      assign fld[i] = to_code(tm[i], bin);
    end
  end

  always_comb begin
    for (int i = 0; i < N_FIELDS; i++) code[i] = fld[i];
  end
endmodule

// File: rtl/rtc_cal_dec.sv
module rtc_cal_dec
  import rtc_cal_pkg::*;
(
  input  tm_t  code,
  input  logic bin,
  input  logic h24,
  output tm_t  tm
);
  logic [7:0] fld [N_FIELDS];

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    if (i == F_HR) begin : g_hr
      logic [7:0] v;
      logic       pm;
      logic [7:0] h;
      always_comb begin
        v  = from_code({1'b0, code[i][6:0]}, bin);
        pm = code[i][7];
        if (v == 8'd12) h = pm ? 8'd12 : 8'd0;
        else            h = pm ? v + 8'd12 : v;
      end
      assign fld[i] = h24 ? from_code(code[i], bin) : h;
    end else begin : g_plain
      assign fld[i] = from_code(code[i], bin);
    end
  end

  always_comb begin
    for (int i = 0; i < N_FIELDS; i++) tm[i] = fld[i];
  end
endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
  import rtc_cal_pkg::*;
#(
  parameter int unsigned UIP_LEAD = 4,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              uip,
  output logic              upd_done
);
  localparam int unsigned CNT_W   = $clog2(UIP_LEAD + 1);
  localparam tm_t         TM_RST  = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};
  localparam logic [3:0]  CTL_RST = 4'b0100;

  logic [1:0]       rst_pipe;
  logic             rst_q_n;
  logic [3:0]       ctl_q, ctl_d;
  tm_t              usr_q, usr_d, int_q, int_d;
  tm_t              step_tm, enc_tm, dec_tm;
  logic             fall_q, fall_d, step_fall;
  logic             busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             xfer, set_now, ctl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  rtc_cal_step u_step (
    .cur(int_q), .dst_en(ctl_q[C_DST]), .fall_seen(fall_q),
    .nxt(step_tm), .fall_seen_nxt(step_fall)
  );

  rtc_cal_enc u_enc (
    .tm(step_tm), .bin(ctl_q[C_BIN]), .h24(ctl_q[C_H24]), .code(enc_tm)
  );

  rtc_cal_dec u_dec (
    .code(usr_q), .bin(ctl_q[C_BIN]), .h24(ctl_q[C_H24]), .tm(dec_tm)
  );

  assign set_now = ctl_q[C_SET];
  assign xfer    = busy_q && (cnt_q == CNT_W'(1));
  assign ctl_wr  = wr_en && (addr == ADDR_W'(A_CTL));

  always_comb begin
    ctl_d  = ctl_q;
    usr_d  = usr_q;
    int_d  = int_q;
    fall_d = fall_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (xfer) begin
      int_d  = step_tm;
      fall_d = step_fall;
      busy_d = 1'b0;
      if (!set_now) begin
        usr_d  = enc_tm;
        done_d = 1'b1;
      end
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (tick_1s) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(UIP_LEAD);
    end
    if (ctl_wr) begin
      ctl_d = wr_data[3:0];
      if (set_now && !wr_data[C_SET]) begin
        int_d  = dec_tm;
        fall_d = 1'b0;
        busy_d = 1'b0;
      end
    end else if (wr_en && set_now) begin
      for (int i = 0; i < N_FIELDS; i++) begin
        if (addr == ADDR_W'(i))
          usr_d[i] = (i == F_SEC) ? {1'b0, wr_data[6:0]} : wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctl_q  <= CTL_RST;
      usr_q  <= TM_RST;
      int_q  <= TM_RST;
      fall_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      usr_q  <= usr_d;
      int_q  <= int_d;
      fall_q <= fall_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < N_FIELDS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = usr_q[i];
    end
    if (addr == ADDR_W'(A_CTL)) rd_data = {4'b0000, ctl_q};
  end

  assign uip      = busy_q && !set_now;
  assign upd_done = done_q;
endmodule

// File: rtl/rtc_update_engine_chk.sv
module rtc_update_engine_chk
  import rtc_cal_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick_1s,
  input logic wr_en,
  input logic uip,
  input logic upd_done,
  input logic set_q,
  input tm_t  usr
);
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  assert_done_after_uip_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(uip));

  assert_uip_from_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick_1s));

  assert_sec_top_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !usr[F_SEC][7]);

  assert_frozen_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && $past(set_q) && !$past(wr_en)) |-> $stable(usr));

  assert_frozen_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q && $past(set_q)) |-> !upd_done);
endmodule

bind rtc_update_engine rtc_update_engine_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .tick_1s(tick_1s), .wr_en(wr_en),
  .uip(uip), .upd_done(upd_done), .set_q(ctl_q[C_SET]), .usr(usr_q)
);

// File: tb/rtc_update_engine_tb.sv
module rtc_update_engine_tb;
  localparam int LEAD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       uip, upd_done;

  int checks = 0;
  int errors = 0;
  bit live = 0;

  always #4 clk = ~clk;

  rtc_update_engine #(.UIP_LEAD(LEAD), .ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .uip(uip), .upd_done(upd_done)
  );

  // ---------------- behavioural reference model ----------------
  int m_t[7];
  int m_u[7];
  int m_ctl, m_busy, m_cnt, m_fall;
  bit m_uip, m_done;

  function automatic int enc(int v, bit bin);
    return bin ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int enc_hr(int h, bit bin, bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return (h >= 12 ? 128 : 0) + enc(h12, bin);
  endfunction
  function automatic int dec(int c, bit bin);
    return bin ? c : (c / 16) * 10 + c % 16;
  endfunction
  function automatic int dec_hr(int c, bit bin, bit h24);
    int v;
    bit pm;
    if (h24) return dec(c, bin);
    v  = dec(c % 128, bin);
    pm = c >= 128;
    if (v == 12) return pm ? 12 : 0;
    return pm ? v + 12 : v;
  endfunction
  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic m_step();
    bit eh, dst;
    eh  = (m_t[1] == 59) && (m_t[0] == 59);
    dst = m_ctl[3];
    if (dst && m_t[5] == 4 && m_t[3] == 1 && m_t[4] <= 7 && m_t[2] == 1 && eh) begin
      m_t[2] = 3; m_t[1] = 0; m_t[0] = 0;
    end else if (dst && m_t[5] == 10 && m_t[3] == 1 && m_t[4] >= 25 && m_t[2] == 1 && eh && m_fall == 0) begin
      m_t[1] = 0; m_t[0] = 0; m_fall = 1;
    end else begin
      if (eh && m_t[2] == 1) m_fall = 0;
      m_t[0]++;
      if (m_t[0] == 60) begin m_t[0] = 0; m_t[1]++; end
      if (m_t[1] == 60) begin m_t[1] = 0; m_t[2]++; end
      if (m_t[2] == 24) begin
        m_t[2] = 0;
        m_t[3] = m_t[3] % 7 + 1;
        m_t[4]++;
        if (m_t[4] > mlen(m_t[5], m_t[6])) begin
          m_t[4] = 1;
          m_t[5]++;
          if (m_t[5] == 13) begin m_t[5] = 1; m_t[6] = (m_t[6] + 1) % 100; end
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : mdl
    bit set_now;
    if (!rst_n) begin
      m_t = '{0, 0, 0, 1, 1, 1, 0};
      m_u = '{0, 0, 0, 1, 1, 1, 0};
      m_ctl = 4; m_busy = 0; m_cnt = 0; m_fall = 0; m_uip = 0; m_done = 0;
    end else begin
      set_now = m_ctl[0];
      m_done  = 0;
      if (m_busy == 1 && m_cnt == 1) begin
        m_step();
        m_busy = 0;
        if (!set_now) begin
          for (int i = 0; i < 7; i++)
            m_u[i] = (i == 2) ? enc_hr(m_t[i], m_ctl[1], m_ctl[2]) : enc(m_t[i], m_ctl[1]);
          m_done = 1;
        end
      end else if (m_busy == 1) begin
        m_cnt--;
      end else if (tick) begin
        m_busy = 1; m_cnt = LEAD;
      end
      if (wr_en && addr == 7) begin
        if (set_now && !wr_data[0]) begin
          for (int i = 0; i < 7; i++)
            m_t[i] = (i == 2) ? dec_hr(m_u[i], m_ctl[1], m_ctl[2]) : dec(m_u[i], m_ctl[1]);
          m_fall = 0; m_busy = 0;
        end
        m_ctl = int'(wr_data[3:0]);
      end else if (wr_en && addr < 7 && set_now) begin
        m_u[addr] = (addr == 0) ? int'(wr_data & 8'h7f) : int'(wr_data);
      end
      m_uip = (m_busy == 1) && !m_ctl[0];
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      check("R12 uip vs model", int'(uip), int'(m_uip));
      check("R12 upd_done vs model", int'(upd_done), int'(m_done));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    @(negedge clk); addr = 4'(a); #1;
    check(tag, int'(rd_data), exp);
  endtask

  task automatic cmp_model(string tag);
    for (int a = 0; a < 7; a++) begin
      @(negedge clk); addr = 4'(a); #1;
      check(tag, int'(rd_data), m_u[a]);
    end
  endtask

  task automatic load(int mode, int s, int mi, int h, int dw, int dt, int mo, int y);
    wr(7, mode | 1);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
    wr(7, mode);
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (LEAD + 1) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 reset state
    rd_chk(0, 8'h00, "R1 sec"); rd_chk(2, 8'h00, "R1 hour");
    rd_chk(3, 8'h01, "R1 dow"); rd_chk(5, 8'h01, "R1 month");
    rd_chk(6, 8'h00, "R1 year"); rd_chk(7, 8'h04, "R1 ctl");

    // R2 full rollover, packed decimal 24h; R12 window timing
    load(4, 8'h59, 8'h59, 8'h23, 7, 8'h31, 8'h12, 8'h99);
    rd_chk(4, 8'h31, "R9 loaded date visible");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; check("R12 uip high first", int'(uip), 1);
    for (int i = 1; i < LEAD; i++) begin
      @(negedge clk); check("R12 uip held", int'(uip), 1);
      check("R12 no early done", int'(upd_done), 0);
    end
    @(negedge clk); check("R12 uip falls", int'(uip), 0); check("R12 done pulse", int'(upd_done), 1);
    @(negedge clk); check("R12 done single", int'(upd_done), 0);
    rd_chk(0, 8'h00, "R2 sec"); rd_chk(2, 8'h00, "R2 hour"); rd_chk(3, 8'h01, "R2 dow wrap");
    rd_chk(4, 8'h01, "R2 date"); rd_chk(5, 8'h01, "R2 month"); rd_chk(6, 8'h00, "R2 year");
    cmp_model("R2 model");

    // R3 encodings
    load(4, 8'h09, 0, 0, 1, 1, 1, 0); pulse(); rd_chk(0, 8'h10, "R3 decimal carry");
    load(6, 8'h09, 0, 0, 1, 1, 1, 0); pulse(); rd_chk(0, 8'h0A, "R3 binary sec");
    load(6, 8'h3B, 8'h3B, 8'h17, 3, 8'h1E, 8'h04, 8'h05); pulse();
    rd_chk(5, 8'h05, "R3 binary month"); rd_chk(4, 8'h01, "R3 binary date");
    rd_chk(3, 8'h04, "R3 binary dow"); pulse(); rd_chk(0, 8'h01, "R3 binary next sec");
    cmp_model("R3 model");

    // R5 leap years
    load(4, 8'h59, 8'h59, 8'h23, 2, 8'h28, 8'h02, 8'h24); pulse(); rd_chk(4, 8'h29, "R5 leap 29");
    load(4, 8'h59, 8'h59, 8'h23, 2, 8'h29, 8'h02, 8'h24); pulse(); rd_chk(5, 8'h03, "R5 leap end");
    load(4, 8'h59, 8'h59, 8'h23, 2, 8'h28, 8'h02, 8'h23); pulse(); rd_chk(4, 8'h01, "R5 common year");
    load(4, 8'h59, 8'h59, 8'h23, 2, 8'h28, 8'h02, 8'h00); pulse(); rd_chk(4, 8'h29, "R5 year 00");

    // R4 12-hour
    load(0, 8'h59, 8'h59, 8'h11, 1, 1, 1, 0); pulse(); rd_chk(2, 8'h92, "R4 noon PM");
    load(0, 8'h59, 8'h59, 8'h92, 1, 1, 1, 0); pulse(); rd_chk(2, 8'h81, "R4 1 PM");
    load(0, 8'h59, 8'h59, 8'h91, 1, 1, 1, 0); pulse(); rd_chk(2, 8'h12, "R4 midnight");
    rd_chk(4, 8'h02, "R4 day advance");
    load(2, 8'h3B, 8'h3B, 8'h0B, 1, 1, 1, 0); pulse(); rd_chk(2, 8'h8C, "R4 binary PM");
    load(2, 8'h3B, 8'h3B, 8'h8B, 1, 1, 1, 0); pulse(); rd_chk(2, 8'h0C, "R4 binary AM");
    cmp_model("R4 model");

    // R6 spring forward
    load(12, 8'h59, 8'h59, 8'h01, 1, 8'h05, 8'h04, 8'h24); pulse(); rd_chk(2, 8'h03, "R6 jump");
    rd_chk(1, 8'h00, "R6 min");
    load(4, 8'h59, 8'h59, 8'h01, 1, 8'h05, 8'h04, 8'h24); pulse(); rd_chk(2, 8'h02, "R6 disabled");
    load(12, 8'h59, 8'h59, 8'h01, 1, 8'h08, 8'h04, 8'h24); pulse(); rd_chk(2, 8'h02, "R6 second week");

    // R7 fall back once
    load(12, 8'h59, 8'h59, 8'h01, 1, 8'h27, 8'h10, 8'h24); pulse();
    rd_chk(2, 8'h01, "R7 back hour"); rd_chk(1, 8'h00, "R7 back min");
    for (int i = 0; i < 3599; i++) pulse();
    rd_chk(0, 8'h59, "R7 reach sec"); rd_chk(2, 8'h01, "R7 reach hour");
    pulse(); rd_chk(2, 8'h02, "R7 second pass");
    cmp_model("R7 model");

    // R8 freeze
    load(4, 8'h00, 8'h00, 8'h10, 1, 8'h01, 8'h06, 8'h24);
    wr(7, 5);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; check("R8 uip low frozen", int'(uip), 0);
    repeat (LEAD + 1) @(negedge clk);
    pulse(); rd_chk(0, 8'h00, "R8 frozen sec");
    wr(7, 4);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; check("R12 uip before set", int'(uip), 1);
    wr_en = 1'b1; addr = 4'd7; wr_data = 8'h05;
    @(negedge clk); wr_en = 1'b0; check("R8 set clears uip", int'(uip), 0);
    repeat (LEAD + 1) @(negedge clk);
    rd_chk(0, 8'h00, "R8 no transfer");

    // R9 load on unfreeze
    wr(0, 8'h30); wr(7, 4); pulse();
    rd_chk(0, 8'h31, "R9 resume sec"); rd_chk(2, 8'h10, "R9 resume hour");

    // R10 writes ignored while running
    wr(1, 8'h45); rd_chk(1, 8'h00, "R10 ignored");

    // R11 seconds top bit
    wr(7, 5); wr(0, 8'hD9); rd_chk(0, 8'h59, "R11 top bit"); wr(7, 4);
    pulse(); rd_chk(0, 8'h00, "R2 sec wrap"); rd_chk(1, 8'h01, "R2 min carry");
    cmp_model("R9 model");

    live = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule